// File: doc/BRIEF.md
# Return and Interrupt-Return Control Unit

This block carries out the two return instructions of a small 8-bit controller core. One of them returns from a subroutine and also puts an 8-bit literal into the working register W. The other returns from an interrupt service routine. The block decodes the 16-bit instruction word that comes with a start strobe. It pops a return-address stack of 31 entries into a 21-bit program counter. For an interrupt return it turns global interrupts back on, and when the instruction asks for it, it reloads W, STATUS and BSR from a fast shadow set. The upper program-counter latch registers are outside this block and never change here.

Call logic fills the stack through a push port. Interrupt entry logic fills the shadow set through a capture strobe. The rest of the datapath writes W, STATUS, BSR and the two enable bits through plain write ports. An accepted return takes one instruction word and two cycles: all of its effects land on the first clock edge, and the block then reports busy for one idle cycle.

Top module: `rtn_ctrl`

## Requirements
- R1: After a synchronous active-high reset, the following are all zero: pc, tos, w, status, bsr, both enable bits, busy, not_handled and underflow. The stack is empty.
- R2: A literal return is any word whose top byte is 8'h0C; bits 7:0 are the literal. When start is high and busy is low, the clock edge loads tos into pc, pops the stack and writes the literal into w. status and bsr keep their values, and pc changes only on an accepted return.
- R3: An interrupt return is 16'h0010 or 16'h0011, with bit 0 as the restore flag. When accepted, it loads tos into pc and pops the stack. With the flag at 0, w, status and bsr are unchanged.
- R4: An accepted interrupt return with the restore flag at 1 copies the shadow W, STATUS and BSR into w, status and bsr on the same edge.
- R5: An accepted interrupt return sets an enable bit and clears none. With prio_mode low it sets gie_hi. With prio_mode high it sets gie_hi if gie_hi is clear, and otherwise sets gie_lo.
- R6: busy is high for exactly the one cycle after an accepted return. A start strobe seen while busy is high has no effect of any kind.
- R7: Any other word accepted with start leaves pc, stack, registers and enables unchanged. It raises not_handled for the next cycle only, and busy stays low.
- R8: A return accepted while the stack is empty loads zero into pc and sets underflow. Underflow stays set until reset.
- R9: shadow_cap copies the current w, status and bsr into the shadow set on that clock edge. A later restore returns exactly those values.
- R10: The stack is last-in first-out with 31 entries, and tos shows the newest entry (zero when empty). A push while full, or in the same cycle as an accepted return, is dropped.
- R11: dp_we loads w, status and bsr from the dp ports. gie_we loads gie_hi from gie_wdata[1] and gie_lo from gie_wdata[0]. Both writes are blocked in a cycle that accepts a return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Instruction strobe |
| instr | input | 16 | Instruction word |
| push | input | 1 | Push request from call logic |
| push_addr | input | 21 | Return address to push |
| shadow_cap | input | 1 | Interrupt-entry capture of W/STATUS/BSR |
| prio_mode | input | 1 | Two-level interrupt priority enabled |
| dp_we | input | 1 | Datapath write of W/STATUS/BSR |
| dp_w | input | 8 | Datapath W value |
| dp_status | input | 5 | Datapath STATUS value |
| dp_bsr | input | 4 | Datapath BSR value |
| gie_we | input | 1 | Datapath write of the enable bits |
| gie_wdata | input | 2 | {high enable, low enable} write value |
| pc | output | 21 | Program counter |
| tos | output | 21 | Top of stack, zero when empty |
| w | output | 8 | Working register |
| status | output | 5 | Status register |
| bsr | output | 4 | Bank-select register |
| gie_hi | output | 1 | Global / high-priority enable |
| gie_lo | output | 1 | Peripheral / low-priority enable |
| busy | output | 1 | Second, idle cycle of a return |
| not_handled | output | 1 | One-cycle pulse for an unrecognised word |
| underflow | output | 1 | Sticky empty-stack pop flag |

## Verification
The bench runs literal returns that carry distinct literals against both forms of the interrupt return, so a wrong write to w, or a restore when the flag is clear, shows up at once. Interrupt returns are repeated under both priority settings and from both states of gie_hi, which tells the single-enable rule apart from the two-level rule. The unrecognised words chosen lie next to the valid encodings (16'h0012, 16'h0D00, 16'h0001), which tests how exact the decode is. The strobe is also held over the busy cycle to show it is ignored there. A full-stack push and pops on an empty stack cover both ends of the stack. A constrained-random phase then mixes pushes, captures and datapath writes with returns in the same cycle.

// File: rtl/rtn_pkg.sv
package rtn_pkg;

    localparam int W_W   = 8;
    localparam int ST_W  = 5;
    localparam int BSR_W = 4;

    localparam logic [7:0]  RETLIT_TOP = 8'h0C;
    localparam logic [14:0] RETINT_TOP = 15'h0008;

    typedef enum logic [1:0] {
        OP_OTHER  = 2'd0,
        OP_RETLIT = 2'd1,
        OP_RETINT = 2'd2
    } op_kind_e;

    typedef struct packed {
        op_kind_e         kind;
        logic [W_W-1:0]   lit;
        logic             fast;
    } dec_t;

    typedef struct packed {
        logic [W_W-1:0]   w;
        logic [ST_W-1:0]  st;
        logic [BSR_W-1:0] bsr;
    } ctx_t;

    function automatic dec_t decode_word(input logic [15:0] iw);
        dec_t d;
        d.lit  = iw[W_W-1:0];
        d.fast = iw[0];
        if (iw[15:8] == RETLIT_TOP)
            d.kind = OP_RETLIT;
        else if (iw[15:1] == RETINT_TOP)
            d.kind = OP_RETINT;
        else
            d.kind = OP_OTHER;
        return d;
    endfunction

endpackage

// File: rtl/rtn_decode.sv
module rtn_decode
    import rtn_pkg::*;
(
    input  logic [15:0] instr,
    output dec_t        dec
);
    always_comb dec = decode_word(instr);
endmodule

// File: rtl/rtn_stack.sv
module rtn_stack #(
    parameter int PC_W  = 21,
    parameter int DEPTH = 31
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            push,
    input  logic [PC_W-1:0] push_addr,
    input  logic            pop,
    output logic [PC_W-1:0] tos,
    output logic            empty,
    output logic            uflow
);
    localparam int SP_W = $clog2(DEPTH + 1);
    localparam logic [SP_W-1:0] SP_FULL = SP_W'(DEPTH);

    logic [PC_W-1:0] mem [DEPTH];
    logic [SP_W-1:0] sp;
    logic            full;
    logic            do_push;

    assign empty   = (sp == '0);
    assign full    = (sp == SP_FULL);
    assign do_push = push && !pop && !full;
    assign tos     = empty ? '0 : mem[sp - SP_W'(1)];

    always_ff @(posedge clk) begin
        if (rst) begin
            sp    <= '0;
            uflow <= 1'b0;
        end else if (pop) begin
            if (empty)
                uflow <= 1'b1;
            else
                sp <= sp - SP_W'(1);
        end else if (do_push) begin
            sp <= sp + SP_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push)
            mem[sp[SP_W-1:0]] <= push_addr;
    end
endmodule

// File: rtl/rtn_ctx.sv
module rtn_ctx
    import rtn_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           dp_we,
    input  ctx_t           dp_ctx,
    input  logic           cap,
    input  logic           restore,
    input  logic           lit_we,
    input  logic [W_W-1:0] lit,
    input  logic           ret_blk,
    output ctx_t           live,
    output ctx_t           shadow
);
    always_ff @(posedge clk) begin
        if (rst) begin
            live <= '0;
        end else if (restore) begin
            live <= shadow;
        end else if (lit_we) begin
            live.w <= lit;
        end else if (dp_we && !ret_blk) begin
            live <= dp_ctx;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            shadow <= '0;
        else if (cap)
            shadow <= live;
    end
endmodule

// File: rtl/rtn_ctrl.sv
module rtn_ctrl
    import rtn_pkg::*;
#(
    parameter int PC_W      = 21,
    parameter int STK_DEPTH = 31
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [15:0]       instr,
    input  logic              push,
    input  logic [PC_W-1:0]   push_addr,
    input  logic              shadow_cap,
    input  logic              prio_mode,
    input  logic              dp_we,
    input  logic [W_W-1:0]    dp_w,
    input  logic [ST_W-1:0]   dp_status,
    input  logic [BSR_W-1:0]  dp_bsr,
    input  logic              gie_we,
    input  logic [1:0]        gie_wdata,
    output logic [PC_W-1:0]   pc,
    output logic [PC_W-1:0]   tos,
    output logic [W_W-1:0]    w,
    output logic [ST_W-1:0]   status,
    output logic [BSR_W-1:0]  bsr,
    output logic              gie_hi,
    output logic              gie_lo,
    output logic              busy,
    output logic              not_handled,
    output logic              underflow
);
    dec_t dec;
    ctx_t live, shadow, dp_ctx;
    logic accept, is_ret, is_bad, is_int, restore, lit_we, stk_empty;

    rtn_decode u_dec (.instr(instr), .dec(dec));

    assign accept  = start && !busy;
    assign is_ret  = accept && (dec.kind != OP_OTHER);
    assign is_bad  = accept && (dec.kind == OP_OTHER);
    assign is_int  = is_ret && (dec.kind == OP_RETINT);
    assign restore = is_int && dec.fast;
    assign lit_we  = is_ret && (dec.kind == OP_RETLIT);
    assign dp_ctx  = '{w: dp_w, st: dp_status, bsr: dp_bsr};

    rtn_stack #(.PC_W(PC_W), .DEPTH(STK_DEPTH)) u_stk (
        .clk(clk), .rst(rst), .push(push), .push_addr(push_addr),
        .pop(is_ret), .tos(tos), .empty(stk_empty), .uflow(underflow)
    );

    rtn_ctx u_ctx (
        .clk(clk), .rst(rst), .dp_we(dp_we), .dp_ctx(dp_ctx),
        .cap(shadow_cap), .restore(restore), .lit_we(lit_we),
        .lit(dec.lit), .ret_blk(is_ret), .live(live), .shadow(shadow)
    );

    assign w      = live.w;
    assign status = live.st;
    assign bsr    = live.bsr;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc          <= '0;
            busy        <= 1'b0;
            not_handled <= 1'b0;
        end else begin
            busy        <= is_ret;
            not_handled <= is_bad;
            if (is_ret)
                pc <= stk_empty ? '0 : tos;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gie_hi <= 1'b0;
            gie_lo <= 1'b0;
        end else if (is_int) begin
            if (!prio_mode || !gie_hi)
                gie_hi <= 1'b1;
            else
                gie_lo <= 1'b1;
        end else if (gie_we && !is_ret) begin
            gie_hi <= gie_wdata[1];
            gie_lo <= gie_wdata[0];
        end
    end
endmodule

// File: rtl/rtn_ctrl_chk.sv
module rtn_ctrl_chk #(
    parameter int PC_W = 21
) (
    input logic            clk,
    input logic            rst,
    input logic            start,
    input logic [15:0]     instr,
    input logic [PC_W-1:0] pc,
    input logic [7:0]      w,
    input logic            gie_hi,
    input logic            gie_lo,
    input logic            busy,
    input logic            not_handled,
    input logic            underflow
);
    logic acc, lit_op, int_op;
    assign acc    = start && !busy;
    assign lit_op = (instr[15:8] == 8'h0C);
    assign int_op = (instr[15:1] == 15'h0008);

    AST_BUSY_SINGLE: assert property (@(posedge clk) disable iff (rst)
        busy |=> !busy);                                             // R6
    AST_RETLIT_W: assert property (@(posedge clk) disable iff (rst)
        (acc && lit_op) |=> (busy && w == $past(instr[7:0])));       // R2
    AST_RETINT_EN: assert property (@(posedge clk) disable iff (rst)
        (acc && int_op) |=> (busy && (gie_hi || gie_lo)));           // R5
    AST_OTHER_PULSE: assert property (@(posedge clk) disable iff (rst)
        (acc && !lit_op && !int_op) |=> (not_handled && !busy));     // R7
    AST_NH_EXCL: assert property (@(posedge clk) disable iff (rst)
        not_handled |-> !busy);                                      // R7
    AST_UF_STICKY: assert property (@(posedge clk) disable iff (rst)
        underflow |=> underflow);                                    // R8
    AST_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
        !acc |=> $stable(pc));                                       // R2
endmodule

bind rtn_ctrl rtn_ctrl_chk #(.PC_W(PC_W)) u_chk (
    .clk(clk), .rst(rst), .start(start), .instr(instr), .pc(pc), .w(w),
    .gie_hi(gie_hi), .gie_lo(gie_lo), .busy(busy),
    .not_handled(not_handled), .underflow(underflow)
);

// File: tb/test_rtn_ctrl.sv
module test_rtn_ctrl;
    localparam int PC_W = 21;
    localparam int DEPTH = 31;

    logic clk = 1'b0;
    logic rst;
    logic start, push, shadow_cap, prio_mode, dp_we, gie_we;
    logic [15:0] instr;
    logic [PC_W-1:0] push_addr;
    logic [7:0] dp_w;
    logic [4:0] dp_status;
    logic [3:0] dp_bsr;
    logic [1:0] gie_wdata;
    logic [PC_W-1:0] pc, tos;
    logic [7:0] w;
    logic [4:0] status;
    logic [3:0] bsr;
    logic gie_hi, gie_lo, busy, not_handled, underflow;

    always #5 clk = ~clk;

    rtn_ctrl i_rtn_ctrl (
        .clk(clk), .rst(rst), .start(start), .instr(instr), .push(push),
        .push_addr(push_addr), .shadow_cap(shadow_cap), .prio_mode(prio_mode),
        .dp_we(dp_we), .dp_w(dp_w), .dp_status(dp_status), .dp_bsr(dp_bsr),
        .gie_we(gie_we), .gie_wdata(gie_wdata), .pc(pc), .tos(tos), .w(w),
        .status(status), .bsr(bsr), .gie_hi(gie_hi), .gie_lo(gie_lo),
        .busy(busy), .not_handled(not_handled), .underflow(underflow)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;
    string phase = "R1 reset";

    // reference model
    logic [PC_W-1:0] m_stk [DEPTH];
    int m_sp;
    logic [PC_W-1:0] m_pc;
    logic [7:0] m_w, m_ws;
    logic [4:0] m_st, m_sts;
    logic [3:0] m_bsr, m_bsrs;
    logic m_hi, m_lo, m_busy, m_nh, m_uf;

    function automatic int classify(input logic [15:0] iw);
        if (iw[15:8] == 8'h0C) return 1;
        if (iw[15:1] == 15'h0008) return 2;
        return 0;
    endfunction

    function automatic logic [PC_W-1:0] m_tos();
        return (m_sp > 0) ? m_stk[m_sp-1] : '0;
    endfunction

    task automatic model_reset();
        m_sp = 0; m_pc = '0; m_w = '0; m_st = '0; m_bsr = '0;
        m_ws = '0; m_sts = '0; m_bsrs = '0;
        m_hi = 0; m_lo = 0; m_busy = 0; m_nh = 0; m_uf = 0;
    endtask

    task automatic model_step();
        bit acc, ret;
        int k;
        logic [7:0] ow, ows;
        logic [4:0] ost, osts;
        logic [3:0] obsr, obsrs;
        ow = m_w; ost = m_st; obsr = m_bsr;
        ows = m_ws; osts = m_sts; obsrs = m_bsrs;
        acc = start && !m_busy;
        k = classify(instr);
        ret = acc && (k != 0);
        m_nh = acc && (k == 0);
        if (shadow_cap) begin            // R9
            m_ws = ow; m_sts = ost; m_bsrs = obsr;
        end
        if (ret) begin
            if (m_sp > 0) begin
                m_pc = m_stk[m_sp-1];
                m_sp--;
            end else begin
                m_pc = '0;                // R8
                m_uf = 1'b1;
            end
            if (k == 1) m_w = instr[7:0];
            else begin
                if (!prio_mode || !m_hi) m_hi = 1'b1; else m_lo = 1'b1;
                if (instr[0]) begin       // R4
                    m_w = ows; m_st = osts; m_bsr = obsrs;
                end
            end
        end else begin
            if (dp_we) begin              // R11
                m_w = dp_w; m_st = dp_status; m_bsr = dp_bsr;
            end
            if (gie_we) begin
                m_hi = gie_wdata[1]; m_lo = gie_wdata[0];
            end
            if (push && m_sp < DEPTH) begin   // R10
                m_stk[m_sp] = push_addr;
                m_sp++;
            end
        end
        m_busy = ret;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s [%s] actual=%0h expected=%0h", tag, phase, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("R2 pc", 32'(pc), 32'(m_pc));
        chk("R10 tos", 32'(tos), 32'(m_tos()));
        chk("R2 w", 32'(w), 32'(m_w));
        chk("R3 status", 32'(status), 32'(m_st));
        chk("R4 bsr", 32'(bsr), 32'(m_bsr));
        chk("R5 gie_hi", 32'(gie_hi), 32'(m_hi));
        chk("R5 gie_lo", 32'(gie_lo), 32'(m_lo));
        chk("R6 busy", 32'(busy), 32'(m_busy));
        chk("R7 not_handled", 32'(not_handled), 32'(m_nh));
        chk("R8 underflow", 32'(underflow), 32'(m_uf));
    endtask

    task automatic idle();
        start = 0; instr = 16'h0000; push = 0; push_addr = '0;
        shadow_cap = 0; dp_we = 0; gie_we = 0;
        dp_w = '0; dp_status = '0; dp_bsr = '0; gie_wdata = '0;
    endtask

    task automatic tick();
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare_all();
        idle();
    endtask

    task automatic do_push(input logic [PC_W-1:0] a);
        push = 1; push_addr = a; tick();
    endtask

    task automatic do_ret(input logic [15:0] iw);
        start = 1; instr = iw; tick();
        tick();
    endtask

    task automatic do_dp(input logic [7:0] a, input logic [4:0] b, input logic [3:0] c);
        dp_we = 1; dp_w = a; dp_status = b; dp_bsr = c; tick();
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog [%s] actual=hung expected=finished", phase);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        idle();
        prio_mode = 0;
        rst = 1;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        compare_all();                               // R1 reset values

        phase = "R10 fill stack";
        for (int i = 0; i < DEPTH; i++) do_push(PC_W'(21'h1000 + i * 3));
        do_push(21'h1FFFFF);                          // dropped, stack full

        phase = "R2 literal return";
        do_dp(8'h55, 5'h0A, 4'h6);
        do_ret(16'h0C00);
        do_ret(16'h0CFF);
        do_ret(16'h0CA5);

        phase = "R6 start held over busy";
        start = 1; instr = 16'h0C3C; tick();
        start = 1; instr = 16'h0C77; tick();         // ignored
        tick();

        phase = "R7 unhandled words";
        do_ret(16'h0012);
        do_ret(16'h0D00);
        do_ret(16'h0001);

        phase = "R3 R5 interrupt return no priority";
        prio_mode = 0;
        do_dp(8'h11, 5'h02, 4'h3);
        do_ret(16'h0010);
        do_ret(16'h0010);

        phase = "R5 priority mode";
        gie_we = 1; gie_wdata = 2'b00; tick();
        prio_mode = 1;
        do_ret(16'h0010);                             // sets high
        do_ret(16'h0010);                             // then low
        gie_we = 1; gie_wdata = 2'b01; tick();
        do_ret(16'h0010);

        phase = "R9 R4 shadow capture and restore";
        do_dp(8'hC3, 5'h15, 4'h9);
        shadow_cap = 1; tick();
        do_dp(8'h01, 5'h01, 4'h1);
        do_ret(16'h0011);
        do_dp(8'h22, 5'h04, 4'h2);
        shadow_cap = 1; dp_we = 1; dp_w = 8'hEE; dp_status = 5'h1F; dp_bsr = 4'hF; tick();
        do_ret(16'h0011);

        phase = "R11 writes blocked by return";
        do_push(21'h0ABCD);
        start = 1; instr = 16'h0010; dp_we = 1; dp_w = 8'h99;
        gie_we = 1; gie_wdata = 2'b00; push = 1; push_addr = 21'h12345; tick();
        tick();

        phase = "R8 empty stack pops";
        while (m_sp > 0) do_ret(16'h0C01);
        do_ret(16'h0C42);
        do_ret(16'h0011);

        phase = "random";
        for (int n = 0; n < 4000; n++) begin
            int r;
            r = $urandom % 8;
            if (r < 2) begin start = 1; instr = {8'h0C, 8'($urandom)}; end
            else if (r < 3) begin start = 1; instr = {15'h0008, 1'($urandom)}; end
            else if (r < 4) begin start = 1; instr = 16'($urandom); end
            push = ($urandom % 2) == 0;
            push_addr = PC_W'($urandom);
            shadow_cap = ($urandom % 8) == 0;
            dp_we = ($urandom % 4) == 0;
            dp_w = 8'($urandom); dp_status = 5'($urandom); dp_bsr = 4'($urandom);
            gie_we = ($urandom % 6) == 0;
            gie_wdata = 2'($urandom);
            if (($urandom % 32) == 0) prio_mode = ~prio_mode;
            tick();
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule